// File: doc/BRIEF.md
# Watchdog Timer with Level or Pulse Reset Output

This block is a watchdog that counts down an 8-bit value once per time unit. The unit is either seconds or minutes, derived from a 1 ms tick input through a prescaler. Software keeps the system alive by rewriting the time register, which reloads the count and restarts the prescaler. When the count runs down to zero, the block latches a sticky timeout flag. If its output is enabled, it also pulls an active-low reset line.

The reset line has two modes. In level mode it stays low until the watchdog is disabled or the time register is rewritten. In pulse mode it stays low for a width picked by a 2-bit code. The watchdog runs only while both the device enable and the control enable are set. All settings go through a byte-wide register write port and a combinational read port.

Register map (byte addresses):
- 0x00: device enable, bit 0.
- 0x01: control. Bits 1:0 are the width code, bit 2 is the unit (1 = minutes), bit 3 is the mode (1 = pulse), bit 4 is the enable, and bit 5 is the timeout status (write 1 to clear).
- 0x02: time. A write reloads the count; a read returns the live count.
- 0x03: output enable, bit 0.

Top module: `wdog_core`

## Requirements
- R1: After reset, `wdt_rst_n` is 1 and every register (addresses 0x00 to 0x03) reads 0.
- R2: Control bits 4:0, device enable bit 0 and output enable bit 0 read back as written; the time address reads the current count.
- R3: Unless device enable and control bit 4 are both 1, the count does not change, except when the time register is written.
- R4: While running with a nonzero count, the count drops by one every SEC_TICKS ticks when bit 2 is 0, and every MIN_TICKS ticks when bit 2 is 1.
- R5: A write to the time register loads the count and restarts the prescaler. If that write falls in the same cycle as the tick that would end the count, the write wins and no expiry occurs.
- R6: On expiry, status bit 5 becomes 1. It stays 1 through a disable and through writes with bit 5 at 0. It is cleared by writing bit 5 as 1. An expiry in the same cycle as that clearing write leaves it set.
- R7: In level mode (bit 3 = 0), `wdt_rst_n` goes low the cycle after expiry. It stays low until the watchdog stops running or the time register is written.
- R8: In pulse mode (bit 3 = 1), `wdt_rst_n` goes low for PW_T0, PW_T1, PW_T2 or PW_T3 ticks, for width codes 0 to 3. A disable or a time write ends the pulse early.
- R9: With output enable at 0, `wdt_rst_n` stays 1, but an expiry still sets the status bit.
- R10: A count of 0 never expires and never changes the status or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle 1 ms time base strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wdt_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
Two pairs of functions can fall in the same cycle.

- The keepalive write to the time register can coincide with the prescaler tick that would take the count from 1 to 0.
- The write-one-to-clear of the status bit can coincide with an expiry.

The bench switches the tick to manual control so it can place the third tick and then fire the fourth together with the register write. It then checks that the reload has won, with no status and no reset pulse. It also checks that the status bit stays set while the output falls. A behavioural reference model, advanced on every edge, checks the output and the read data in every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] A_DEVEN = 8'h00;
  localparam logic [7:0] A_CTRL  = 8'h01;
  localparam logic [7:0] A_TIME  = 8'h02;
  localparam logic [7:0] A_OUTEN = 8'h03;

  localparam int CB_UNIT  = 2;
  localparam int CB_PULSE = 3;
  localparam int CB_EN    = 4;
  localparam int CB_STAT  = 5;

  typedef struct packed {
    logic       en;
    logic       pulse;
    logic       unit_min;
    logic [1:0] width;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       expire,
  input  logic [7:0] count_q,
  output logic [7:0] reg_rdata,
  output logic       dev_en,
  output logic       out_en,
  output ctrl_t      ctrl,
  output logic       status,
  output logic       time_wr
);
  logic  wr_ctrl, wr_deven, wr_outen;
  logic  status_d;
  ctrl_t ctrl_d;
  logic  unused_wbits;

  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_deven = reg_we && (reg_addr == A_DEVEN);
  assign wr_outen = reg_we && (reg_addr == A_OUTEN);
  assign time_wr  = reg_we && (reg_addr == A_TIME);
  assign unused_wbits = ^reg_wdata[7:6];

  always_comb begin
    ctrl_d   = '{en: reg_wdata[CB_EN], pulse: reg_wdata[CB_PULSE],
                 unit_min: reg_wdata[CB_UNIT], width: reg_wdata[1:0]};
    // a new expiry outranks a clearing write
    status_d = expire | (status & ~(wr_ctrl & reg_wdata[CB_STAT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      status <= 1'b0;
      dev_en <= 1'b0;
      out_en <= 1'b0;
    end else begin
      status <= status_d;
      if (wr_ctrl)  ctrl   <= ctrl_d;
      if (wr_deven) dev_en <= reg_wdata[0];
      if (wr_outen) out_en <= reg_wdata[0];
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_DEVEN: reg_rdata = {7'd0, dev_en};
      A_CTRL:  reg_rdata = {2'd0, status, ctrl};
      A_TIME:  reg_rdata = count_q;
      A_OUTEN: reg_rdata = {7'd0, out_en};
      default: reg_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int SEC_TICKS = 1000,
  parameter int MIN_TICKS = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       unit_min,
  input  logic       time_wr,
  input  logic [7:0] time_val,
  output logic [7:0] count_q,
  output logic       expire
);
  localparam int PRESC_W = $clog2(MIN_TICKS + 1);
  localparam logic [PRESC_W-1:0] SEC_LAST = PRESC_W'(SEC_TICKS - 1);
  localparam logic [PRESC_W-1:0] MIN_LAST = PRESC_W'(MIN_TICKS - 1);

  logic [PRESC_W-1:0] presc_q, presc_d, last;
  logic [7:0]         count_d;
  logic               active, step;

  assign last   = unit_min ? MIN_LAST : SEC_LAST;
  assign active = run && tick && (count_q != 8'd0);
  assign step   = active && (presc_q >= last);
  assign expire = !time_wr && step && (count_q == 8'd1);

  always_comb begin
    presc_d = presc_q;
    count_d = count_q;
    if (time_wr) begin
      presc_d = '0;
      count_d = time_val;
    end else if (!run) begin
      presc_d = '0;
    end else if (step) begin
      presc_d = '0;
      count_d = count_q - 8'd1;
    end else if (active) begin
      presc_d = presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      count_q <= 8'd0;
    end else begin
      presc_q <= presc_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/wdog_shaper.sv
module wdog_shaper #(
  parameter int PW_T0 = 1,
  parameter int PW_T1 = 25,
  parameter int PW_T2 = 125,
  parameter int PW_T3 = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       time_wr,
  input  logic       expire,
  input  logic       pulse_mode,
  input  logic [1:0] width_code,
  input  logic       out_en,
  output logic       wdt_rst_n
);
  localparam int PC_W = $clog2(PW_T3 + 1);

  logic            lvl_q, lvl_d;
  logic [PC_W-1:0] pcnt_q, pcnt_d, width;

  always_comb begin
    unique case (width_code)
      2'd0:    width = PC_W'(PW_T0);
      2'd1:    width = PC_W'(PW_T1);
      2'd2:    width = PC_W'(PW_T2);
      default: width = PC_W'(PW_T3);
    endcase
  end

  always_comb begin
    lvl_d  = lvl_q;
    pcnt_d = pcnt_q;
    if (!run || time_wr) begin
      lvl_d  = 1'b0;
      pcnt_d = '0;
    end else if (expire) begin
      if (pulse_mode) pcnt_d = width;
      else            lvl_d  = 1'b1;
    end else if (tick && (pcnt_q != '0)) begin
      pcnt_d = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign wdt_rst_n = ~((lvl_q | (pcnt_q != '0)) & out_en);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int SEC_TICKS = 1000,
  parameter int MIN_TICKS = 60000,
  parameter int PW_T0     = 1,
  parameter int PW_T1     = 25,
  parameter int PW_T2     = 125,
  parameter int PW_T3     = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst_n
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       dev_en, out_en, status, time_wr, expire, run;
  logic [7:0] count_q;
  ctrl_t      ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign run = dev_en && ctrl.en;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .expire(expire), .count_q(count_q),
    .reg_rdata(reg_rdata), .dev_en(dev_en), .out_en(out_en), .ctrl(ctrl),
    .status(status), .time_wr(time_wr)
  );

  wdog_counter #(.SEC_TICKS(SEC_TICKS), .MIN_TICKS(MIN_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .run(run),
    .unit_min(ctrl.unit_min), .time_wr(time_wr), .time_val(reg_wdata),
    .count_q(count_q), .expire(expire)
  );

  wdog_shaper #(.PW_T0(PW_T0), .PW_T1(PW_T1), .PW_T2(PW_T2), .PW_T3(PW_T3)) u_shp (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .run(run), .time_wr(time_wr),
    .expire(expire), .pulse_mode(ctrl.pulse), .width_code(ctrl.width),
    .out_en(out_en), .wdt_rst_n(wdt_rst_n)
  );
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk
  import wdog_pkg::*;
(
  input logic       clk,
  input logic       rst_n_s,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       run,
  input logic       time_wr,
  input logic       expire,
  input logic       status,
  input logic       out_en,
  input logic [7:0] count_q,
  input logic       wdt_rst_n
);
  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wdt_rst_n |-> out_en); // R9
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    status && !(reg_we && reg_addr == A_CTRL && reg_wdata[CB_STAT]) |=> status); // R6
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n_s)
    expire |=> status); // R6
  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run && !time_wr |=> $stable(count_q)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !time_wr && count_q != 8'd0 |=> (count_q == $past(count_q) || count_q == $past(count_q) - 8'd1)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    time_wr |=> count_q == $past(reg_wdata)); // R5
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    count_q == 8'd0 |-> !expire); // R10
endmodule

bind wdog_core wdog_core_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run(run), .time_wr(time_wr), .expire(expire),
  .status(status), .out_en(out_en), .count_q(count_q), .wdt_rst_n(wdt_rst_n)
);

// File: tb/tb_wdog_core.sv
`timescale 1ns/1ps
module tb_wdog_core;
  localparam int SEC = 4, MINU = 10;
  localparam int P0 = 1, P1 = 2, P2 = 3, P3 = 6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'd0, reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic wdt_rst_n;
  int checks = 0, fails = 0, cyc = 0;
  bit auto_tick = 1'b0;
  int tphase = 0;

  wdog_core #(.SEC_TICKS(SEC), .MIN_TICKS(MINU), .PW_T0(P0), .PW_T1(P1),
              .PW_T2(P2), .PW_T3(P3)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_n(wdt_rst_n));

  always #10 clk = ~clk;

  // reference model state
  int m_deven, m_outen, m_unit, m_pulse, m_width, m_en, m_stat;
  int m_count, m_presc, m_lvl, m_pcnt;
  int run_i, lim_i, wt_i, wc_i, ex_i;

  function automatic int pw_of(int code);
    case (code)
      0: return P0;
      1: return P1;
      2: return P2;
      default: return P3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_deven = 0; m_outen = 0; m_unit = 0; m_pulse = 0; m_width = 0; m_en = 0;
      m_stat = 0; m_count = 0; m_presc = 0; m_lvl = 0; m_pcnt = 0;
    end else begin
      run_i = m_deven & m_en;
      lim_i = m_unit ? MINU : SEC;
      wt_i = (reg_we && reg_addr == 8'h02) ? 1 : 0;
      wc_i = (reg_we && reg_addr == 8'h01) ? 1 : 0;
      ex_i = 0;
      if (wt_i != 0) begin m_count = reg_wdata; m_presc = 0; end
      else if (run_i == 0) m_presc = 0;
      else if (tick && m_count != 0) begin
        if (m_presc + 1 >= lim_i) begin
          m_presc = 0;
          if (m_count == 1) ex_i = 1;
          m_count = m_count - 1;
        end else m_presc = m_presc + 1;
      end
      if (run_i == 0 || wt_i != 0) begin m_lvl = 0; m_pcnt = 0; end
      else if (ex_i != 0) begin
        if (m_pulse != 0) m_pcnt = pw_of(m_width); else m_lvl = 1;
      end else if (tick && m_pcnt > 0) m_pcnt = m_pcnt - 1;
      if (ex_i != 0) m_stat = 1;
      else if (wc_i != 0 && reg_wdata[5]) m_stat = 0;
      if (wc_i != 0) begin
        m_width = reg_wdata[1:0]; m_unit = reg_wdata[2];
        m_pulse = reg_wdata[3]; m_en = reg_wdata[4];
      end
      if (reg_we && reg_addr == 8'h00) m_deven = reg_wdata[0];
      if (reg_we && reg_addr == 8'h03) m_outen = reg_wdata[0];
    end
  end

  function automatic logic [7:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return 8'(m_deven);
      8'h01: return 8'((m_stat << 5) | (m_en << 4) | (m_pulse << 3) | (m_unit << 2) | m_width);
      8'h02: return 8'(m_count);
      8'h03: return 8'(m_outen);
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cyc > 4) begin
      logic exp_o;
      exp_o = !(((m_lvl != 0) || (m_pcnt > 0)) && (m_outen != 0));
      check(wdt_rst_n == exp_o, "R8 model output", wdt_rst_n, exp_o);
      check(reg_rdata == m_read(reg_addr), "R2 model readback", reg_rdata, m_read(reg_addr));
    end
  end

  always @(negedge clk) begin
    #1;
    if (auto_tick) begin
      tick = (tphase == 2);
      tphase = (tphase + 1) % 3;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1; reg_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; tick = 1'b1;
    @(negedge clk); #1; reg_we = 1'b0; tick = 1'b0;
  endtask

  task automatic mtick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; tick = 1'b1;
      @(negedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); #1; reg_addr = a; #4; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_low(input int maxc, output int n);
    n = 0;
    while (wdt_rst_n && n < maxc) begin @(negedge clk); #5; n++; end
  endtask

  initial begin
    logic [7:0] v;
    int n, lowc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(8'(a), v);
      check(v == 8'd0, "R1 reset register", v, 0);
    end
    check(wdt_rst_n == 1'b1, "R1 reset output", wdt_rst_n, 1);
    // R2 readback
    wr(8'h01, 8'h0B); rd(8'h01, v); check(v == 8'h0B, "R2 ctrl readback", v, 8'h0B);
    wr(8'h03, 8'h01); rd(8'h03, v); check(v == 8'h01, "R2 outen readback", v, 1);
    // R3 frozen while device disabled
    wr(8'h01, 8'h10); wr(8'h02, 8'd5);
    auto_tick = 1'b1;
    idle(90); rd(8'h02, v); check(v == 8'd5, "R3 count frozen", v, 5);
    check(wdt_rst_n == 1'b1, "R3 no expiry", wdt_rst_n, 1);
    // R4 seconds, R7 level
    wr(8'h00, 8'h01); wr(8'h02, 8'd3);
    wait_low(60, n);
    check(n > 30 && n < 40, "R4 seconds expiry time", n, 36);
    idle(40); check(wdt_rst_n == 1'b0, "R7 level held", wdt_rst_n, 0);
    rd(8'h01, v); check(v[5] == 1'b1, "R6 status set", v[5], 1);
    wr(8'h02, 8'd0); idle(1); check(wdt_rst_n == 1'b1, "R7 rewrite releases", wdt_rst_n, 1);
    idle(100); check(wdt_rst_n == 1'b1, "R10 zero count quiet", wdt_rst_n, 1);
    wr(8'h01, 8'h10); rd(8'h01, v); check(v[5] == 1'b1, "R6 write 0 keeps", v[5], 1);
    wr(8'h01, 8'h30); rd(8'h01, v); check(v[5] == 1'b0, "R6 W1C clears", v[5], 0);
    // R4 minutes
    wr(8'h01, 8'h14); wr(8'h02, 8'd1);
    idle(22); check(wdt_rst_n == 1'b1, "R4 minutes not yet", wdt_rst_n, 1);
    idle(14); check(wdt_rst_n == 1'b0, "R4 minutes expired", wdt_rst_n, 0);
    wr(8'h01, 8'h04); idle(1);
    check(wdt_rst_n == 1'b1, "R7 disable releases", wdt_rst_n, 1);
    rd(8'h01, v); check(v[5] == 1'b1, "R6 sticky through disable", v[5], 1);
    wr(8'h01, 8'h20);
    // R8 pulse width code 2
    wr(8'h01, 8'h1A); wr(8'h02, 8'd1);
    wait_low(60, n);
    lowc = 0;
    while (!wdt_rst_n && lowc < 50) begin @(negedge clk); #5; lowc++; end
    check(lowc == 3 * P2, "R8 pulse width", lowc, 3 * P2);
    idle(30); check(wdt_rst_n == 1'b1, "R8 pulse over", wdt_rst_n, 1);
    // R9 output disabled
    wr(8'h01, 8'h30); wr(8'h03, 8'h00); wr(8'h02, 8'd1);
    idle(40); check(wdt_rst_n == 1'b1, "R9 output gated", wdt_rst_n, 1);
    rd(8'h01, v); check(v[5] == 1'b1, "R9 status still set", v[5], 1);
    // R5 collision: keepalive on the final tick
    auto_tick = 1'b0; idle(2); tick = 1'b0;
    wr(8'h03, 8'h01); wr(8'h01, 8'h30); wr(8'h02, 8'd1);
    mtick(3); wr_tick(8'h02, 8'd2);
    idle(1); check(wdt_rst_n == 1'b1, "R5 write wins output", wdt_rst_n, 1);
    rd(8'h01, v); check(v[5] == 1'b0, "R5 write wins status", v[5], 0);
    rd(8'h02, v); check(v == 8'd2, "R5 reload value", v, 2);
    // R6 collision: expiry with W1C
    wr(8'h02, 8'd1); mtick(4);
    rd(8'h01, v); check(v[5] == 1'b1, "R6 manual expiry", v[5], 1);
    wr(8'h02, 8'd1); mtick(3); wr_tick(8'h01, 8'h30);
    idle(1); rd(8'h01, v); check(v[5] == 1'b1, "R6 set beats clear", v[5], 1);
    check(wdt_rst_n == 1'b0, "R7 collision asserts", wdt_rst_n, 0);
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule